// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command decoder of a byte-wide electrically erasable memory, written as a synthesizable state machine clocked by a system clock. It watches the external chip enable, write enable and output enable strobes, a 17-bit address and an 8-bit data bus. It decodes write cycles into operating modes: array read, identifier read, erase, erase-verify, program, program-verify and a two-write reset. It drives the read-data path and gives level strobes for program and erase to an array interface. A stop timer ends a program or erase that runs too long, and the controller then waits in an idle state until it gets another command.

A write cycle is seen as a falling and then a rising edge of write enable while chip enable is low. The address is taken at the falling edge and the data byte at the rising edge. A byte is accepted as a command only when the programming-supply flag is high. The memory cells are outside the block. The array answers combinationally on `arr_rdata` for the address the block puts on `arr_addr`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A command is accepted only at a clock where write enable is seen rising while chip enable is low and `vpp_hi` is 1. Write pulses with `vpp_hi` at 0, or with chip enable high, leave the mode unchanged.
- R2: The address of a write cycle is the one present at the clock where write enable is first seen low. The data byte is the one present at the clock where write enable is seen high again. Values on the buses at other times are not used.
- R3: After reset the mode is array read, and a read returns `arr_rdata` for the live address. Command 00h also selects array read. In the two set-up modes and after a single FFh, reads also return the array.
- R4: Command 90h selects identifier read. Address 0 returns 89h, address 1 returns B4h and any other address returns 00h.
- R5: Command 20h arms erase. A second 20h raises `erase_busy` starting the clock after that write. Any other byte after 20h is decoded as a fresh command.
- R6: Command 40h arms program. The next write cycle's address and data appear on `arr_addr` and `arr_wdata`, and `prog_busy` goes high starting the clock after it. `prog_busy` and `erase_busy` are never high together.
- R7: Command C0h makes reads return the array at the last programmed address. Command A0h makes reads return the array at the address taken with that A0h write. In both cases the live address has no effect.
- R8: FFh written in any mode, including program set-up, arms a reset and programs nothing. A second FFh right after it selects array read. The array is left unchanged.
- R9: With no write during it, a program stays busy for exactly PROG_LIMIT clocks and an erase for exactly ERASE_LIMIT clocks. The controller then becomes inactive. While inactive, `dout_en` is 0 until a command is accepted.
- R10: Any byte that is not 00h, 90h, 20h, 40h, C0h, A0h or FFh selects array read.
- R11: `dout_en` is 1 only when chip enable and output enable are low, write enable is high, and the mode is not program, erase or inactive. `dout` is 00h whenever `dout_en` is 0.
- R12: A write accepted during a program or an erase ends that operation at the same clock. Its byte is decoded as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming supply present |
| addr | input | ADDR_W (17) | Bus address |
| din | input | 8 | Bus data in |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Read data drive enable |
| arr_addr | output | ADDR_W (17) | Array address |
| arr_wdata | output | 8 | Byte to program |
| arr_rdata | input | 8 | Array read data |
| prog_busy | output | 1 | Program strobe to array |
| erase_busy | output | 1 | Erase strobe to array |

## Verification
The bench builds the controller with PROG_LIMIT = 12 and ERASE_LIMIT = 30 in place of the long defaults. With these limits both stop-timer expiries happen within a few dozen clocks. Program and erase runs that a later write ends early still fit inside the limits, so early termination and timer expiry are both tested in the same short run. The 17-bit address is kept, and the bench array decodes only the low four address bits. Scrambled upper bits during write pulses therefore show whether the address was taken at the right edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] CMD_READ   = 8'h00;
    localparam logic [DATA_W-1:0] CMD_IDENT  = 8'h90;
    localparam logic [DATA_W-1:0] CMD_ERASE  = 8'h20;
    localparam logic [DATA_W-1:0] CMD_PROG   = 8'h40;
    localparam logic [DATA_W-1:0] CMD_PVFY   = 8'hC0;
    localparam logic [DATA_W-1:0] CMD_EVFY   = 8'hA0;
    localparam logic [DATA_W-1:0] CMD_RESET  = 8'hFF;

    localparam logic [DATA_W-1:0] ID_MAKER   = 8'h89;
    localparam logic [DATA_W-1:0] ID_PART    = 8'hB4;

    typedef enum logic [3:0] {
        M_READ,
        M_IDENT,
        M_ERASE_ARM,
        M_ERASING,
        M_ERASE_VFY,
        M_PROG_ARM,
        M_PROGRAM,
        M_PROG_VFY,
        M_RESET_ARM,
        M_INACTIVE
    } mode_t;

    function automatic mode_t decode_byte(input logic [DATA_W-1:0] d);
        mode_t r;
        case (d)
            CMD_READ:  r = M_READ;
            CMD_IDENT: r = M_IDENT;
            CMD_ERASE: r = M_ERASE_ARM;
            CMD_PROG:  r = M_PROG_ARM;
            CMD_PVFY:  r = M_PROG_VFY;
            CMD_EVFY:  r = M_ERASE_VFY;
            CMD_RESET: r = M_RESET_ARM;
            default:   r = M_READ;
        endcase
        return r;
    endfunction

    function automatic mode_t next_on_commit(input mode_t cur, input logic [DATA_W-1:0] d);
        mode_t r;
        r = decode_byte(d);
        case (cur)
            M_PROG_ARM:  r = (d == CMD_RESET) ? M_RESET_ARM : M_PROGRAM;
            M_ERASE_ARM: if (d == CMD_ERASE) r = M_ERASING;
            M_RESET_ARM: if (d == CMD_RESET) r = M_READ;
            default: ;
        endcase
        return r;
    endfunction

    function automatic logic is_busy(input mode_t m);
        return (m == M_PROGRAM) || (m == M_ERASING);
    endfunction

endpackage

// File: rtl/flash_bus_sampler.sv
module flash_bus_sampler #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              vpp_hi,
    input  logic [ADDR_W-1:0] addr,
    output logic              commit,
    output logic [ADDR_W-1:0] cap_addr
);
    logic we_q;
    logic fall_seen;

    assign fall_seen = we_q && !we_n && !ce_n;
    assign commit    = !we_q && we_n && !ce_n && vpp_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q     <= 1'b1;
            cap_addr <= '0;
        end else begin
            we_q <= we_n;
            if (fall_seen) cap_addr <= addr;
        end
    end
endmodule

// File: rtl/flash_stop_timer.sv
module flash_stop_timer #(
    parameter int PROG_LIMIT  = 1000,
    parameter int ERASE_LIMIT = 950000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    input  logic erase_sel,
    output logic expire
);
    localparam int MAX_LIM = (PROG_LIMIT > ERASE_LIMIT) ? PROG_LIMIT : ERASE_LIMIT;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last   = erase_sel ? CNT_W'(ERASE_LIMIT - 1) : CNT_W'(PROG_LIMIT - 1);
    assign expire = run && !start && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || start) cnt <= '0;
        else if (run)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  mode_t             mode,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] live_addr,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [ADDR_W-1:0] vfy_addr,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    logic [DATA_W-1:0] id_val;

    always_comb begin
        case (mode)
            M_PROGRAM, M_PROG_VFY: arr_addr = prog_addr;
            M_ERASE_VFY:           arr_addr = vfy_addr;
            default:               arr_addr = live_addr;
        endcase
    end

    always_comb begin
        if (live_addr == '0)                 id_val = ID_MAKER;
        else if (live_addr == ADDR_W'(1))    id_val = ID_PART;
        else                                 id_val = '0;
    end

    assign dout_en = !ce_n && !oe_n && we_n && !is_busy(mode) && (mode != M_INACTIVE);

    always_comb begin
        if (!dout_en)             dout = '0;
        else if (mode == M_IDENT) dout = id_val;
        else                      dout = arr_rdata;
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int PROG_LIMIT  = 1000,
    parameter int ERASE_LIMIT = 950000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    input  logic [7:0]        arr_rdata,
    output logic              prog_busy,
    output logic              erase_busy
);
    mode_t             state;
    mode_t             nxt;
    logic              commit;
    logic              expire;
    logic              start;
    logic [ADDR_W-1:0] cap_addr;
    logic [ADDR_W-1:0] prog_addr;
    logic [ADDR_W-1:0] vfy_addr;
    logic [7:0]        prog_data;

    flash_bus_sampler #(.ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .vpp_hi(vpp_hi),
        .addr(addr), .commit(commit), .cap_addr(cap_addr)
    );

    assign nxt   = next_on_commit(state, din);
    assign start = commit && is_busy(nxt);

    flash_stop_timer #(.PROG_LIMIT(PROG_LIMIT), .ERASE_LIMIT(ERASE_LIMIT)) u_timer (
        .clk(clk), .rst(rst), .start(start), .run(is_busy(state)),
        .erase_sel(state == M_ERASING), .expire(expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= M_READ;
            prog_addr <= '0;
            prog_data <= '1;
            vfy_addr  <= '0;
        end else if (commit) begin
            state <= nxt;
            if (nxt == M_PROGRAM) begin
                prog_addr <= cap_addr;
                prog_data <= din;
            end
            if (nxt == M_ERASE_VFY) vfy_addr <= cap_addr;
        end else if (expire) begin
            state <= M_INACTIVE;
        end
    end

    flash_read_mux #(.ADDR_W(ADDR_W)) u_rd (
        .mode(state), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .live_addr(addr), .prog_addr(prog_addr), .vfy_addr(vfy_addr),
        .arr_rdata(arr_rdata), .arr_addr(arr_addr), .dout(dout), .dout_en(dout_en)
    );

    assign arr_wdata  = prog_data;
    assign prog_busy  = (state == M_PROGRAM);
    assign erase_busy = (state == M_ERASING);
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int PROG_LIMIT  = 1000,
    parameter int ERASE_LIMIT = 950000
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              vpp_hi,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dout,
    input logic              dout_en,
    input logic              prog_busy,
    input logic              erase_busy,
    input mode_t             mode
);
    int unsigned prog_run;
    int unsigned erase_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_run  <= 0;
            erase_run <= 0;
        end else begin
            prog_run  <= prog_busy  ? prog_run + 1  : 0;
            erase_run <= erase_busy ? erase_run + 1 : 0;
        end
    end

    // R1: without supply, only a timer expiry may move the mode
    p_no_cmd_without_vpp_r1: assert property (@(posedge clk) disable iff (rst)
        (!vpp_hi && !prog_busy && !erase_busy) |=> $stable(mode));

    // R4: maker code on address zero
    p_ident_maker_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == M_IDENT && dout_en && addr == '0) |-> (dout == 8'h89));

    // R5: erase only starts from the erase set-up mode
    p_erase_from_arm_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(erase_busy) |-> ($past(mode) == M_ERASE_ARM));

    // R6: program only starts from the program set-up mode
    p_prog_from_arm_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_busy) |-> ($past(mode) == M_PROG_ARM));

    // R6: strobes exclusive
    p_strobes_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(prog_busy && erase_busy));

    // R9: bounded program run
    p_prog_bounded_r9: assert property (@(posedge clk) disable iff (rst)
        prog_busy |-> (prog_run < PROG_LIMIT));

    // R9: bounded erase run
    p_erase_bounded_r9: assert property (@(posedge clk) disable iff (rst)
        erase_busy |-> (erase_run < ERASE_LIMIT));

    // R11: drive only on a clean read cycle
    p_drive_rule_r11: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> (!ce_n && !oe_n && we_n && !prog_busy && !erase_busy));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(
    .ADDR_W(ADDR_W), .PROG_LIMIT(PROG_LIMIT), .ERASE_LIMIT(ERASE_LIMIT)
) u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .addr(addr), .dout(dout), .dout_en(dout_en), .prog_busy(prog_busy),
    .erase_busy(erase_busy), .mode(state)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
    localparam int CLK_PER = 10;
    localparam int AW      = 17;
    localparam int PLIM    = 12;
    localparam int ELIM    = 30;

    // reference mode codes
    localparam int K_READ = 0, K_ID = 1, K_EARM = 2, K_ERASE = 3, K_EVFY = 4;
    localparam int K_PARM = 5, K_PROG = 6, K_PVFY = 7, K_RARM = 8, K_IDLE = 9;

    logic          clk = 0;
    logic          rst = 1;
    logic          ce_n = 1, we_n = 1, oe_n = 1, vpp_hi = 0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout, arr_wdata, arr_rdata;
    logic          dout_en, prog_busy, erase_busy;
    logic [AW-1:0] arr_addr;

    int n_tot = 0, n_bad = 0;
    int prog_rises = 0;
    bit done = 0;

    always #(CLK_PER/2) clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW), .PROG_LIMIT(PLIM), .ERASE_LIMIT(ELIM)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .prog_busy(prog_busy),
        .erase_busy(erase_busy)
    );

    // behavioural array driven by the strobes, low four address bits decoded
    logic [7:0] ram [16];
    logic prog_q = 0, erase_q = 0;
    initial for (int i = 0; i < 16; i++) ram[i] = 8'hFF;
    assign arr_rdata = ram[arr_addr[3:0]];
    always @(posedge clk) begin
        prog_q  <= prog_busy;
        erase_q <= erase_busy;
        if (prog_busy && !prog_q) begin
            ram[arr_addr[3:0]] <= ram[arr_addr[3:0]] & arr_wdata;
            prog_rises++;
        end
        if (erase_busy && !erase_q)
            for (int i = 0; i < 16; i++) ram[i] <= 8'hFF;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model
    int         m_mode = K_READ;
    int         m_cnt  = 0;
    bit         m_weq  = 1;
    int         m_la = 0, m_pa = 0, m_va = 0;
    logic [7:0] m_mem [16];
    bit         live = 0;
    initial for (int i = 0; i < 16; i++) m_mem[i] = 8'hFF;

    function automatic int fresh(input logic [7:0] d);
        case (d)
            8'h00: return K_READ;
            8'h90: return K_ID;
            8'h20: return K_EARM;
            8'h40: return K_PARM;
            8'hC0: return K_PVFY;
            8'hA0: return K_EVFY;
            8'hFF: return K_RARM;
            default: return K_READ;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = K_READ; m_weq = 1; m_cnt = 0; m_pa = 0; m_va = 0; m_la = 0;
        end else begin
            live = 1;
            if (!m_weq && we_n && !ce_n && vpp_hi) begin
                int nm;
                if (m_mode == K_PARM) nm = (din == 8'hFF) ? K_RARM : K_PROG;
                else if (m_mode == K_EARM && din == 8'h20) nm = K_ERASE;
                else if (m_mode == K_RARM && din == 8'hFF) nm = K_READ;
                else nm = fresh(din);
                if (nm == K_PROG) begin
                    m_pa = m_la;
                    m_mem[m_la[3:0]] = m_mem[m_la[3:0]] & din;
                end
                if (nm == K_ERASE) for (int i = 0; i < 16; i++) m_mem[i] = 8'hFF;
                if (nm == K_EVFY) m_va = m_la;
                if (nm == K_PROG || nm == K_ERASE) m_cnt = 0;
                m_mode = nm;
            end else if (m_mode == K_PROG || m_mode == K_ERASE) begin
                m_cnt++;
                if (m_cnt == ((m_mode == K_PROG) ? PLIM : ELIM)) m_mode = K_IDLE;
            end
            if (m_weq && !we_n && !ce_n) m_la = int'(addr);
            m_weq = we_n;
        end
    end

    // compare on every clock, mid-cycle
    always @(negedge clk) begin
        if (live && !rst) begin
            bit         en;
            logic [7:0] ex;
            string      t;
            en = !ce_n && !oe_n && we_n && !(m_mode inside {K_PROG, K_ERASE, K_IDLE});
            t  = "R3 array read";
            if (!en) ex = 8'h00;
            else if (m_mode == K_ID) begin
                ex = (addr == 0) ? 8'h89 : (addr == 1) ? 8'hB4 : 8'h00; t = "R4 ident";
            end else if (m_mode == K_PVFY) begin ex = m_mem[m_pa[3:0]]; t = "R7 pvfy"; end
            else if (m_mode == K_EVFY) begin ex = m_mem[m_va[3:0]]; t = "R7 evfy"; end
            else ex = m_mem[addr[3:0]];
            check("R11 cycle dout_en", dout_en, en);
            check({t, " cycle dout"}, dout, ex);
            check("R6 cycle prog_busy", prog_busy, m_mode == K_PROG);
            check("R5 cycle erase_busy", erase_busy, m_mode == K_ERASE);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d, input bit use_ce = 1);
        @(posedge clk); #1 ce_n = !use_ce; oe_n = 1; we_n = 0; addr = AW'(a); din = 8'h5A;
        @(posedge clk); #1 addr = ~AW'(a); din = ~d;
        @(posedge clk); #1 we_n = 1; din = d;
        @(posedge clk); #1 ce_n = 1; din = 8'h00; addr = '0;
    endtask

    task automatic rd(input int a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1 ce_n = 0; oe_n = 0; we_n = 1; addr = AW'(a);
        @(negedge clk);
        check({tag, " read"}, dout, exp);
        check({tag, " read enable"}, dout_en, 1'b1);
        @(posedge clk); #1 ce_n = 1; oe_n = 1;
    endtask

    task automatic rd_off(input int a, input string tag);
        @(posedge clk); #1 ce_n = 0; oe_n = 0; we_n = 1; addr = AW'(a);
        @(negedge clk);
        check({tag, " drive off"}, dout_en, 1'b0);
        check({tag, " dout zero"}, dout, 8'h00);
        @(posedge clk); #1 ce_n = 1; oe_n = 1;
    endtask

    initial begin
        int pr;
        idle(3); #1 rst = 0;
        rd(5, 8'hFF, "R3 reset");
        vpp_hi = 1;
        // program with scrambled address/data mid-pulse (R2, R6, R7)
        wr(0, 8'h40); wr(5, 8'h3C);
        check("R6 prog strobe", prog_busy, 1'b1);
        check("R2 program address", arr_addr, AW'(5));
        check("R6 program data", arr_wdata, 8'h3C);
        idle(2);
        wr(0, 8'hC0);
        check("R12 prog ended", prog_busy, 1'b0);
        rd(9, 8'h3C, "R7 pvfy ignores live address");
        // identifier (R4)
        wr(0, 8'h90);
        rd(0, 8'h89, "R4 maker"); rd(1, 8'hB4, "R4 part"); rd(2, 8'h00, "R4 other");
        wr(0, 8'h00); rd(5, 8'h3C, "R3 read cmd");
        // commands ignored (R1)
        vpp_hi = 0; wr(0, 8'h90); rd(0, 8'hFF, "R1 no vpp");
        vpp_hi = 1; wr(0, 8'h90, 0); rd(0, 8'hFF, "R1 chip disabled");
        // program timeout (R9)
        wr(0, 8'h40); wr(7, 8'h0F); idle(PLIM + 4);
        check("R9 prog expired", prog_busy, 1'b0);
        rd_off(7, "R9 inactive");
        wr(0, 8'h00); rd(7, 8'h0F, "R9 read after timeout");
        // unrecognised byte (R10)
        wr(0, 8'h90); wr(0, 8'h55); rd(0, 8'hFF, "R10 unknown to read");
        // double reset from program set-up (R8)
        pr = prog_rises;
        wr(0, 8'h40); wr(3, 8'hFF);
        rd(1, 8'hFF, "R8 reset armed reads array");
        wr(0, 8'hFF);
        check("R8 nothing programmed", prog_rises, pr);
        rd(5, 8'h3C, "R8 array intact"); rd(0, 8'hFF, "R8 read mode");
        // erase then erase-verify (R5, R7, R12)
        wr(0, 8'h20); wr(0, 8'h20);
        check("R5 erase strobe", erase_busy, 1'b1);
        idle(3);
        wr(5, 8'hA0);
        check("R12 erase ended", erase_busy, 1'b0);
        rd(0, 8'hFF, "R7 evfy");
        wr(0, 8'h40); wr(4, 8'h81); wr(0, 8'hA0);
        rd(4, 8'hFF, "R7 evfy uses captured address");
        wr(0, 8'h00); rd(4, 8'h81, "R3 programmed byte");
        // erase timeout (R9)
        wr(0, 8'h20); wr(0, 8'h20); idle(ELIM + 4);
        check("R9 erase expired", erase_busy, 1'b0);
        rd_off(0, "R9 erase inactive");
        wr(0, 8'h00);
        // 20h then other byte, then a command during program (R5, R12)
        wr(0, 8'h20); wr(0, 8'h40);
        check("R5 no erase after 20h 40h", erase_busy, 1'b0);
        wr(9, 8'hA5);
        check("R5 second byte decoded as program arm", prog_busy, 1'b1);
        wr(0, 8'h90);
        check("R12 prog stopped", prog_busy, 1'b0);
        rd(1, 8'hB4, "R12 new command taken");
        wr(0, 8'h00); rd(9, 8'hA5, "R3 read back");
        // output gating with write low (R11)
        @(posedge clk); #1 ce_n = 0; oe_n = 0; we_n = 0; addr = AW'(9);
        @(negedge clk);
        check("R11 write low blocks drive", dout_en, 1'b0);
        @(posedge clk); #1 ce_n = 1;
        @(posedge clk); #1 we_n = 1; oe_n = 1;
        rd(9, 8'hA5, "R11 still read mode");
        idle(2);
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                n_tot++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule